// File: doc/BRIEF.md
# Inter-thread cell window address map

This block holds the configuration that places a bank of inter-thread communication cells in the memory map and says how accesses into that bank are decoded. Software programs two 64-bit configuration words through a simple register port. Each word is selected by a doubleword-aligned register offset. Only some bits of each word are writable, and the rest keep their value.

From the first word the block drives the storage window's base address and enable. From the second word it drives the window size and the spacing between cells. A new size is accepted only when it is a power of two. The block also decodes a storage offset presented by downstream logic into two parts. One is a cell index, clamped to the last cell when it runs past the bank. The other is a 4-bit access-view code.

Writes to any other configuration slot are dropped and flagged with a one-cycle error pulse. Reads of those slots return zero.

Top module: `xcomm_addr_map`

## Requirements
- R1: The configuration slot is `cfg_addr >> 3`, and `cfg_addr[2:0]` has no effect. `cfg_rdata` is combinational from `cfg_addr`: slot 0 returns word A, slot 1 returns word B, and any slot of 2 or above returns 0.
- R2: A write to slot 0 updates only bits [31:10] and bit 0 of word A (mask 0xFFFFFC01). All other bits of word A keep their previous value.
- R3: A write to slot 1 updates only bits [16:10] (window-mask field) and bits [2:0] (grain field) of word B (mask 0x1FC07). All other bits of word B keep their previous value, including the cell count held in bits [27:20].
- R4: After reset, the outputs and words take these values:
  - word A is 0;
  - word B is 0xC00 | (NUM_CELLS << 20);
  - `win_base` is 0 and `win_en` is 0;
  - `win_size` is 4096.
- R5: `win_base` equals word A with bits [9:0] cleared, and `win_en` equals word A bit 0. Both take a written value from the cycle after the write.
- R6: The candidate size is 1024 + (word B & 0x1FC00). A write to slot 1 loads this candidate into `win_size` only if the candidate is a power of two. Otherwise `win_size` keeps its previous value.
- R7: The cell index is `st_offset >> (7 + grain)`, where grain is word B bits [2:0]. The cell stride therefore runs from 128 bytes to 16 KiB.
- R8: A computed cell index at or above NUM_CELLS is output as NUM_CELLS-1.
- R9: `st_view` equals `st_offset[6:3]`.
- R10: A write to slot 2 or above changes neither word. It sets `cfg_err` high for exactly the one cycle after the write, and `cfg_err` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | REG_AW | Configuration byte offset |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Configuration read data (combinational) |
| cfg_err | output | 1 | One-cycle pulse after a write to a non-writable slot |
| win_base | output | 32 | Storage window base address |
| win_en | output | 1 | Storage window enable |
| win_size | output | 18 | Storage window size in bytes |
| st_offset | input | OFS_W | Storage offset to decode |
| st_cell | output | CELL_W | Decoded, clamped cell index |
| st_view | output | 4 | Decoded access-view code |

## Verification
The assertions check the following on every cycle:
- the read-only bits of both words never move;
- `win_size` is always a power of two and changes only on a slot-1 write;
- the cell index never reaches NUM_CELLS;
- a dropped write leaves both words alone and raises the error pulse;
- slot 0 writes reach the base and enable outputs one cycle later.

Only the bench scenarios can show the arithmetic values. These are the exact size accepted for each of the 128 mask-field settings, and the index and view for every offset under all eight grains. They also include which readback value each write pattern produces.

// File: rtl/xcomm_addr_map.sv
module xcomm_addr_map #(
  parameter int NUM_CELLS = 32,
  parameter int REG_AW    = 6,
  parameter int OFS_W     = 20,
  localparam int CELL_W   = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  output logic              cfg_err,
  output logic [31:0]       win_base,
  output logic              win_en,
  output logic [17:0]       win_size,
  input  logic [OFS_W-1:0]  st_offset,
  output logic [CELL_W-1:0] st_cell,
  output logic [3:0]        st_view
);
  localparam int          IDX_W   = REG_AW - 3;
  localparam logic [63:0] MASK_A  = 64'hFFFF_FC01;
  localparam logic [63:0] MASK_B  = 64'h0001_FC07;
  localparam logic [63:0] RESET_B = 64'h0000_0C00 | (64'(NUM_CELLS) << 20);

  logic [63:0]      word_a, word_b, next_b;
  logic [IDX_W-1:0] slot;
  logic             wr_a, wr_b, wr_bad;
  logic [17:0]      cand_size;
  logic [3:0]       shamt;
  logic [OFS_W-1:0] raw_cell;
  logic             unused_bits;

  assign slot        = cfg_addr[REG_AW-1:3];
  assign unused_bits = ^cfg_addr[2:0];
  assign wr_a        = cfg_wr && (slot == IDX_W'(0));
  assign wr_b        = cfg_wr && (slot == IDX_W'(1));
  assign wr_bad      = cfg_wr && (slot >= IDX_W'(2));

  assign next_b    = (cfg_wdata & MASK_B) | (word_b & ~MASK_B);
  assign cand_size = 18'h400 + {1'b0, next_b[16:10], 10'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_a   <= '0;
      word_b   <= RESET_B;
      win_size <= 18'h1000;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= wr_bad;
      if (wr_a) word_a <= (cfg_wdata & MASK_A) | (word_a & ~MASK_A);
      if (wr_b) begin
        word_b <= next_b;
        if ((cand_size & (cand_size - 18'd1)) == 18'd0) win_size <= cand_size;
      end
    end
  end

  always_comb begin
    case (slot)
      IDX_W'(0): cfg_rdata = word_a;
      IDX_W'(1): cfg_rdata = word_b;
      default:   cfg_rdata = '0;
    endcase
  end

  assign win_base = {word_a[31:10], 10'b0};
  assign win_en   = word_a[0];

  assign shamt    = 4'd7 + {1'b0, word_b[2:0]};
  assign raw_cell = st_offset >> shamt;
  assign st_cell  = (raw_cell >= OFS_W'(NUM_CELLS)) ? CELL_W'(NUM_CELLS - 1)
                                                    : CELL_W'(raw_cell);
  assign st_view  = st_offset[6:3];

  assert_ro_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(word_a & ~MASK_A));
  assert_ro_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(word_b & ~MASK_B));
  assert_rd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot >= IDX_W'(2)) |-> (cfg_rdata == 64'd0));
  assert_base_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> (win_base[31:10] == $past(cfg_wdata[31:10])) && (win_en == $past(cfg_wdata[0])));
  assert_size_pow2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_size) == 1);
  assert_size_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_b |=> $stable(win_size));
  assert_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(st_cell) < NUM_CELLS);
  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> cfg_err && $stable(word_a) && $stable(word_b));
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bad |=> !cfg_err);
endmodule

// File: tb/xcomm_addr_map_bench.sv
module xcomm_addr_map_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 5;
  localparam int AW = 6;
  localparam int OW = 16;
  localparam int CW = $clog2(NC);

  logic          clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [63:0]   cfg_wdata = '0, cfg_rdata;
  logic          cfg_err, win_en;
  logic [31:0]   win_base;
  logic [17:0]   win_size;
  logic [OW-1:0] st_offset = '0;
  logic [CW-1:0] st_cell;
  logic [3:0]    st_view;

  int checks = 0, errors = 0, cycles = 0;
  logic [63:0] exp_a, exp_b;
  logic [17:0] exp_size;

  xcomm_addr_map #(.NUM_CELLS(NC), .REG_AW(AW), .OFS_W(OW)) u_xcomm_addr_map (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .win_base(win_base), .win_en(win_en), .win_size(win_size),
    .st_offset(st_offset), .st_cell(st_cell), .st_view(st_view));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [63:0] e, input string tag);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, tag, cfg_rdata, e);
  endtask

  task automatic wr_b(input logic [63:0] d);
    wr(6'd8, d);
    exp_b = (d & 64'h1FC07) | (exp_b & ~64'h1FC07);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    exp_a = 64'd0;
    exp_b = 64'hC00 | (64'(NC) << 20);
    exp_size = 18'h1000;
    rd_chk(6'd0, exp_a, "R4 word A");
    rd_chk(6'd8, exp_b, "R4 word B");
    chk(win_size == exp_size, "R4 size", 64'(win_size), 64'(exp_size));
    chk(win_en == 1'b0 && win_base == 32'd0, "R4 window", {win_base, 31'd0, win_en}, 64'd0);
    chk(cfg_err == 1'b0, "R4 err", 64'(cfg_err), 64'd0);

    // R2 and R5: masked writes to word A
    foreach (exp_a[i]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [63:0] d;
      case (k)
        0: d = '1;
        1: d = 64'h1234_5678_9ABC_DEF1;
        2: d = 64'hFFFF_FFFF_0000_03FE;
        default: d = 64'h0F0F_F0F0_A5A5_5A5A;
      endcase
      wr(6'd0, d);
      exp_a = d & 64'hFFFF_FC01;
      rd_chk(6'd0, exp_a, "R2 word A readback");
      chk(win_base == {d[31:10], 10'b0}, "R5 base", 64'(win_base), 64'({d[31:10], 10'b0}));
      chk(win_en == d[0], "R5 enable", 64'(win_en), 64'(d[0]));
    end

    // R1 low address bits ignored, every slot read
    for (int s = 0; s < 8; s++) begin
      for (int lo = 0; lo < 8; lo += 3) begin
        logic [63:0] e;
        e = (s == 0) ? exp_a : (s == 1) ? exp_b : 64'd0;
        rd_chk(AW'(s*8 + lo), e, "R1 slot read");
      end
    end

    // R3 and R6: sweep the mask field
    for (int f = 0; f < 128; f++) begin
      int cand;
      wr_b((64'hFFFF_FFFF_FFF0_0000) | (64'(f) << 10) | 64'(f & 7));
      cand = 1024 + f * 1024;
      if ((cand & (cand - 1)) == 0) exp_size = 18'(cand);
      rd_chk(6'd8, exp_b, "R3 word B readback");
      chk(win_size == exp_size, "R6 size", 64'(win_size), 64'(exp_size));
    end

    // R10 dropped writes
    for (int s = 2; s < 8; s++) begin
      wr(AW'(s*8), '1);
      chk(cfg_err == 1'b1, "R10 err pulse", 64'(cfg_err), 64'd1);
      rd_chk(6'd0, exp_a, "R10 word A kept");
      rd_chk(6'd8, exp_b, "R10 word B kept");
      @(negedge clk);
      chk(cfg_err == 1'b0, "R10 err one cycle", 64'(cfg_err), 64'd0);
    end

    // R7 R8 R9: every grain over the offset space
    for (int g = 0; g < 8; g++) begin
      wr_b((64'h3 << 10) | 64'(g));
      for (int off = 0; off < (1 << OW); off += 8) begin
        int ec;
        st_offset = OW'(off);
        #1;
        ec = off >> (7 + g);
        if (ec >= NC) ec = NC - 1;
        chk(int'(st_cell) == ec, (ec == NC - 1) ? "R8 clamp" : "R7 cell index",
            64'(st_cell), 64'(ec));
        chk(st_view == 4'((off >> 3) & 15), "R9 view", 64'(st_view), 64'((off >> 3) & 15));
      end
    end

    finish_run();
  end
endmodule